// File: doc/BRIEF.md
# Three-Source Vectored Interrupt Controller

This block handles interrupts for a small 8-bit processor core. It watches three request sources: an external interrupt pin, an overflow pulse from a timer/event counter, and an end-of-conversion pulse from an analog-to-digital converter. Each source has a request flag and an enable bit. A global enable sits over all of them. The enables and flags share one 8-bit register that the core can write and read at any time.

Requests are serviced only in a cycle where the instruction-phase strobe is high. On such a strobe the block looks at the enabled, flagged sources. If the global enable is set and the core's call stack is not full, it takes the highest-priority one. Taking a request clears that source's flag and the global enable. On the next clock the block issues a one-cycle call request that carries the fixed vector address of the source. It then waits for the core to acknowledge that call before it can take another request. When the core executes a return-from-interrupt, it raises a return pulse, and that pulse sets the global enable again.

Top module: `irq_vector_ctrl`

## Requirements
- R1: The register read value is {0, adc flag, timer flag, ext flag, adc enable, timer enable, ext enable, global enable}, from bit 7 down to bit 0. Bit 7 always reads 0. A write loads bits 6..0. Every bit resets to 0.
- R2: The external flag (bit 4) is set three clocks after the pin goes from high to low, because the pin passes through a two-flop synchronizer. A pin that is low from reset, a rising edge, or a pin held low does not set the flag.
- R3: A one-cycle timer overflow pulse sets bit 5 at the next clock. A one-cycle conversion-done pulse sets bit 6 at the next clock.
- R4: When a hardware flag-set pulse and a register write that clears the same flag arrive in the same cycle, the flag ends up set.
- R5: A request is taken only in a cycle where all of these hold: the phase strobe is high, the stack-full input is low, the global enable is 1, and the source's enable and flag are both 1.
- R6: If several requests qualify in the same cycle, the external source wins first, then the timer, then the converter.
- R7: A taken request drives call_req high for exactly the one cycle after the strobe. During that cycle call_vec is 0x04 for external, 0x08 for timer, or 0x0C for converter.
- R8: Taking a request clears the global enable and that source's flag. All other register bits keep their values.
- R9: A return-from-interrupt pulse sets the global enable at the next clock. It leaves all other bits unchanged.
- R10: After a call, no further request is taken until call_ack has been seen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ext_pin | input | 1 | Asynchronous external interrupt pin, active on its falling edge |
| tmr_ovf | input | 1 | One-cycle timer overflow pulse |
| adc_eoc | input | 1 | One-cycle conversion-done pulse |
| phase_stb | input | 1 | Instruction-phase strobe; requests are taken only when it is high |
| stack_full | input | 1 | High when the core's call stack is full |
| reg_wr | input | 1 | Register write enable |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read value |
| ret_irq | input | 1 | Return-from-interrupt pulse |
| call_ack | input | 1 | Core acknowledge of a call |
| call_req | output | 1 | One-cycle call request |
| call_vec | output | VEC_W | Vector address for the call |

## Verification
Two of the block's functions can act on the same register in the same cycle:

- **Software write and hardware flag-set.** The bench provokes this by driving a write that clears the register and a timer or converter pulse on the same clock edge. The flag must read back set while every other bit reads clear.
- **Take and register update.** The bench provokes this with an exhaustive sweep over all 128 writable register values, with the stack both full and not full. For each case it computes arithmetically which source should win, the vector it should carry, and the value the register should read after the clear.

// File: rtl/irqv_pkg.sv
package irqv_pkg;
  localparam int NSRC     = 3;
  localparam int REG_W    = 8;
  localparam int GIE_BIT  = 0;
  localparam int EN_LSB   = 1;
  localparam int FLAG_LSB = 4;
  localparam int SRC_EXT  = 0;
  localparam int SRC_TMR  = 1;
  localparam int SRC_ADC  = 2;
endpackage

// File: rtl/irqv_pin_sync.sv
module irqv_pin_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic pin,
  output logic fall
);
  logic [STAGES-1:0] sh;
  logic              last;

  always_ff @(posedge clk) begin
    if (rst) begin
      sh   <= '0;
      last <= 1'b0;
    end else begin
      sh   <= {sh[STAGES-2:0], pin};
      last <= sh[STAGES-1];
    end
  end

  // falling edge only after a high sample has been seen
  assign fall = last & ~sh[STAGES-1];
endmodule

// File: rtl/irqv_ctl_reg.sv
module irqv_ctl_reg
  import irqv_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             wr,
  input  logic [REG_W-1:0] wdata,
  input  logic [NSRC-1:0]  hw_set,
  input  logic             take,
  input  logic [NSRC-1:0]  take_sel,
  input  logic             reti,
  output logic             gie,
  output logic [NSRC-1:0]  en,
  output logic [NSRC-1:0]  flag,
  output logic [REG_W-1:0] rdata
);
  logic gie_nx;

  always_comb begin
    gie_nx = gie;
    if (wr)   gie_nx = wdata[GIE_BIT];
    if (reti) gie_nx = 1'b1;
    if (take) gie_nx = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst) gie <= 1'b0;
    else     gie <= gie_nx;
  end

  for (genvar i = 0; i < NSRC; i++) begin : g_src
    logic flag_nx;

    always_comb begin
      flag_nx = flag[i];
      if (wr)                flag_nx = wdata[FLAG_LSB+i];
      if (take && take_sel[i]) flag_nx = 1'b0;
      if (hw_set[i])         flag_nx = 1'b1;
    end

    always_ff @(posedge clk) begin
      if (rst) begin
        en[i]   <= 1'b0;
        flag[i] <= 1'b0;
      end else begin
        if (wr) en[i] <= wdata[EN_LSB+i];
        flag[i] <= flag_nx;
      end
    end
  end

  assign rdata = {1'b0, flag, en, gie};
endmodule

// File: rtl/irqv_arbiter.sv
module irqv_arbiter
  import irqv_pkg::*;
#(
  parameter int VEC_W    = 8,
  parameter int VEC_STEP = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             stb,
  input  logic             stack_full,
  input  logic             gie,
  input  logic [NSRC-1:0]  en,
  input  logic [NSRC-1:0]  flag,
  input  logic             ack,
  output logic             take,
  output logic [NSRC-1:0]  take_sel,
  output logic             call_req,
  output logic [VEC_W-1:0] call_vec
);
  logic [NSRC-1:0]  pending;
  logic [VEC_W-1:0] vec_nx;
  logic             busy;

  assign pending = flag & en & {NSRC{gie}};

  // lowest index wins
  always_comb begin
    take_sel = '0;
    vec_nx   = '0;
    for (int i = NSRC-1; i >= 0; i--) begin
      if (pending[i]) begin
        take_sel = '0;
        take_sel[i] = 1'b1;
        vec_nx = VEC_W'(VEC_STEP * (i + 1));
      end
    end
  end

  assign take = stb & ~stack_full & ~busy & (|pending);

  always_ff @(posedge clk) begin
    if (rst) begin
      call_req <= 1'b0;
      call_vec <= '0;
      busy     <= 1'b0;
    end else begin
      call_req <= take;
      if (take) call_vec <= vec_nx;
      if (take)     busy <= 1'b1;
      else if (ack) busy <= 1'b0;
    end
  end
endmodule

// File: rtl/irq_vector_ctrl.sv
module irq_vector_ctrl
  import irqv_pkg::*;
#(
  parameter int VEC_W       = 8,
  parameter int VEC_STEP    = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ext_pin,
  input  logic             tmr_ovf,
  input  logic             adc_eoc,
  input  logic             phase_stb,
  input  logic             stack_full,
  input  logic             reg_wr,
  input  logic [7:0]       reg_wdata,
  output logic [7:0]       reg_rdata,
  input  logic             ret_irq,
  input  logic             call_ack,
  output logic             call_req,
  output logic [VEC_W-1:0] call_vec
);
  logic            ext_fall;
  logic [NSRC-1:0] hw_set;
  logic            gie;
  logic [NSRC-1:0] en;
  logic [NSRC-1:0] flag;
  logic            take;
  logic [NSRC-1:0] take_sel;

  irqv_pin_sync #(.STAGES(SYNC_STAGES)) i_sync (
    .clk(clk), .rst(rst), .pin(ext_pin), .fall(ext_fall)
  );

  always_comb begin
    hw_set          = '0;
    hw_set[SRC_EXT] = ext_fall;
    hw_set[SRC_TMR] = tmr_ovf;
    hw_set[SRC_ADC] = adc_eoc;
  end

  irqv_ctl_reg i_reg (
    .clk(clk), .rst(rst), .wr(reg_wr), .wdata(reg_wdata),
    .hw_set(hw_set), .take(take), .take_sel(take_sel), .reti(ret_irq),
    .gie(gie), .en(en), .flag(flag), .rdata(reg_rdata)
  );

  irqv_arbiter #(.VEC_W(VEC_W), .VEC_STEP(VEC_STEP)) i_arb (
    .clk(clk), .rst(rst), .stb(phase_stb), .stack_full(stack_full),
    .gie(gie), .en(en), .flag(flag), .ack(call_ack),
    .take(take), .take_sel(take_sel),
    .call_req(call_req), .call_vec(call_vec)
  );
endmodule

// File: rtl/irqv_checker.sv
module irqv_checker #(
  parameter int VEC_W    = 8,
  parameter int VEC_STEP = 4
) (
  input logic             clk,
  input logic             rst,
  input logic             phase_stb,
  input logic             stack_full,
  input logic             ret_irq,
  input logic [7:0]       reg_rdata,
  input logic             call_req,
  input logic [VEC_W-1:0] call_vec
);
  AST_BIT7_ZERO: assert property (@(posedge clk) disable iff (rst)
    !reg_rdata[7]); // R1
  AST_CALL_ON_STROBE: assert property (@(posedge clk) disable iff (rst)
    call_req |-> $past(phase_stb)); // R5
  AST_NO_CALL_STACK_FULL: assert property (@(posedge clk) disable iff (rst)
    call_req |-> !$past(stack_full)); // R5
  AST_EXT_FIRST: assert property (@(posedge clk) disable iff (rst)
    (call_req && call_vec != VEC_W'(VEC_STEP)) |-> !$past(reg_rdata[4] & reg_rdata[1])); // R6
  AST_TMR_BEFORE_ADC: assert property (@(posedge clk) disable iff (rst)
    (call_req && call_vec == VEC_W'(3*VEC_STEP)) |-> !$past(reg_rdata[5] & reg_rdata[2])); // R6
  AST_CALL_PULSE: assert property (@(posedge clk) disable iff (rst)
    call_req |=> !call_req); // R7
  AST_VEC_LEGAL: assert property (@(posedge clk) disable iff (rst)
    call_req |-> (call_vec == VEC_W'(VEC_STEP) || call_vec == VEC_W'(2*VEC_STEP) ||
                  call_vec == VEC_W'(3*VEC_STEP))); // R7
  AST_GIE_CLEARED: assert property (@(posedge clk) disable iff (rst)
    call_req |-> !reg_rdata[0]); // R8
  AST_RETI_SETS_GIE: assert property (@(posedge clk) disable iff (rst)
    ($past(ret_irq) && !call_req) |-> reg_rdata[0]); // R9
endmodule

bind irq_vector_ctrl irqv_checker #(.VEC_W(VEC_W), .VEC_STEP(VEC_STEP)) i_chk (
  .clk(clk), .rst(rst), .phase_stb(phase_stb), .stack_full(stack_full),
  .ret_irq(ret_irq), .reg_rdata(reg_rdata), .call_req(call_req), .call_vec(call_vec)
);

// File: tb/test_irq_vector_ctrl.sv
`timescale 1ns/1ps
module test_irq_vector_ctrl;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       ext_pin = 1'b0, tmr_ovf = 1'b0, adc_eoc = 1'b0;
  logic       phase_stb = 1'b0, stack_full = 1'b0;
  logic       reg_wr = 1'b0;
  logic [7:0] reg_wdata = '0;
  logic [7:0] reg_rdata;
  logic       ret_irq = 1'b0, call_ack = 1'b0;
  logic       call_req;
  logic [7:0] call_vec;

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;

  always #4 clk = ~clk;

  irq_vector_ctrl i_irq_vector_ctrl (
    .clk(clk), .rst(rst), .ext_pin(ext_pin), .tmr_ovf(tmr_ovf), .adc_eoc(adc_eoc),
    .phase_stb(phase_stb), .stack_full(stack_full), .reg_wr(reg_wr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .ret_irq(ret_irq),
    .call_ack(call_ack), .call_req(call_req), .call_vec(call_vec)
  );

  task automatic tick(int n = 1);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(string tag, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic wr_reg(logic [7:0] v);
    reg_wr = 1'b1; reg_wdata = v;
    tick();
    reg_wr = 1'b0;
  endtask

  task automatic strobe(logic full);
    stack_full = full; phase_stb = 1'b1;
    tick();
    phase_stb = 1'b0; stack_full = 1'b0;
  endtask

  task automatic ack();
    call_ack = 1'b1;
    tick();
    call_ack = 1'b0;
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin : main
    tick(3);
    rst = 1'b0;
    tick(5);
    chk("R1 reset value", reg_rdata, 8'h00);
    chk("R2 pin low from reset no flag", reg_rdata[4], 0);

    // R2: rising edge does not set, falling edge sets after three clocks
    ext_pin = 1'b1; tick(5);
    chk("R2 rising edge no flag", reg_rdata[4], 0);
    ext_pin = 1'b0; tick(2);
    chk("R2 flag not yet set", reg_rdata[4], 0);
    tick();
    chk("R2 flag set on falling edge", reg_rdata[4], 1);
    wr_reg(8'h00); tick(4);
    chk("R2 held low no re-set", reg_rdata[4], 0);
    ext_pin = 1'b1; tick(4);

    // R1: write readback with bit 7 masked
    wr_reg(8'hFF);
    chk("R1 bit7 reads 0", reg_rdata, 8'h7F);
    wr_reg(8'h2A);
    chk("R1 readback", reg_rdata, 8'h2A);

    // R3: hardware pulses
    wr_reg(8'h00);
    tmr_ovf = 1'b1; tick(); tmr_ovf = 1'b0;
    chk("R3 timer flag", reg_rdata, 8'h20);
    wr_reg(8'h00);
    adc_eoc = 1'b1; tick(); adc_eoc = 1'b0;
    chk("R3 adc flag", reg_rdata, 8'h40);

    // R4: hardware set beats a clearing write
    reg_wr = 1'b1; reg_wdata = 8'h00; tmr_ovf = 1'b1;
    tick(); reg_wr = 1'b0; tmr_ovf = 1'b0;
    chk("R4 timer set over write", reg_rdata, 8'h20);
    reg_wr = 1'b1; reg_wdata = 8'h00; adc_eoc = 1'b1;
    tick(); reg_wr = 1'b0; adc_eoc = 1'b0;
    chk("R4 adc set over write", reg_rdata, 8'h40);

    // R9: return-from-interrupt sets the global enable only
    wr_reg(8'h24);
    ret_irq = 1'b1; tick(); ret_irq = 1'b0;
    chk("R9 reti sets gie", reg_rdata, 8'h25);

    // R10: no second take before acknowledge
    wr_reg(8'h13);
    strobe(1'b0);
    chk("R10 first call", call_req, 1);
    chk("R7 first vec", call_vec, 8'h04);
    tick();
    wr_reg(8'h13);
    strobe(1'b0);
    chk("R10 blocked before ack", call_req, 0);
    chk("R10 flag kept while blocked", reg_rdata, 8'h13);
    ack();
    strobe(1'b0);
    chk("R10 call after ack", call_req, 1);
    ack();

    // R5 R6 R7 R8: exhaustive sweep of register contents and stack state
    for (int full = 0; full < 2; full++) begin
      for (int c = 0; c < 128; c++) begin
        logic [7:0] v, exp_reg;
        logic [2:0] pend;
        int win;
        v = 8'(c);
        wr_reg(v);
        tick();
        chk("R5 no call without strobe", call_req, 0);
        pend = v[6:4] & v[3:1] & {3{v[0]}} & {3{full == 0}};
        win = -1;
        for (int i = 2; i >= 0; i--) if (pend[i]) win = i;
        exp_reg = v;
        if (win >= 0) begin
          exp_reg[0] = 1'b0;
          exp_reg[4+win] = 1'b0;
        end
        strobe(full[0]);
        chk("R5 take condition", call_req, (win >= 0) ? 1 : 0);
        chk("R8 register after strobe", reg_rdata, exp_reg);
        if (win >= 0) begin
          chk("R6 R7 vector", call_vec, 4 * (win + 1));
          ack();
          chk("R7 single-cycle pulse", call_req, 0);
        end
      end
    end

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule